// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Stage

This block is the fetch stage of a five-stage pipelined processor. Its instructions are byte-encoded and take 1, 2, 5 or 6 bytes. Each cycle the stage receives a fetch PC from the PC-select logic outside the block. It puts that address on a combinational instruction memory port and gets back a window of six consecutive bytes, starting at the fetch PC.

The stage decodes the window into a record and writes it into the fetch/decode pipeline register. The record holds:
- the opcode and function nibbles;
- the two register specifiers;
- a 32-bit constant, assembled little-endian;
- the next sequential PC;
- the PC of the instruction itself;
- a two-bit status.

The next sequential PC is also written into a PC register. That register is the prediction for the following fetch.

A fetch address beyond the memory, or an undefined opcode, does not stop the stage. Either one yields a record tagged with its own status. The hazard logic outside the block drives three plain controls:
- a stall for the PC register;
- a stall for the fetch/decode register;
- a bubble for the fetch/decode register.

The stage has no streaming handshake. Back-pressure is expressed only through these stall and bubble pins: a stalled register keeps its value, and the window presented in that cycle is discarded.

Top module: `fetch_stage`

## Requirements
- R1: The upper nibble of the first byte appears on `fd_icode` and the lower nibble on `fd_ifun`.
- R2: Opcodes 2, 3, 4, 5, 6, 0xA and 0xB carry a register byte at offset 1. Its upper nibble goes to `fd_ra` and its lower nibble to `fd_rb`. For all other opcodes both fields are 0xF.
- R3: Opcodes 3, 4 and 5 carry a constant at offsets 2..5, and opcodes 7 and 8 carry one at offsets 1..4. The lowest address is the least significant byte. All other opcodes give `fd_valc` = 0, and window bytes beyond memory read as 0.
- R4: `fd_valp` = fetch PC + 1, plus 1 if a register byte is present, plus 4 if a constant is present.
- R5: A fetch PC at or above `MEM_BYTES` gives opcode 1, function 0 and status 2. Both register fields are 0xF, the constant is 0 and `fd_valp` is the PC + 1.
- R6: Opcodes above 0xB give status 3, with no register byte and no constant. Any other fetched opcode gives status 1.
- R7: `fd_pc` captures the fetch PC of the record.
- R8: With neither stall nor bubble, the record for the PC presented before a rising edge appears on the `fd_*` outputs right after that edge.
- R9: Reset, or `fd_bubble` at an edge, loads the bubble record: opcode 1, function 0, registers 0xF, constant 0, `fd_valp` 0, `fd_pc` 0, status 0. The bubble wins over `fd_stall`.
- R10: `fd_stall` without `fd_bubble` holds every `fd_*` output.
- R11: `pred_pc` resets to `RESET_PC`. At each edge without `pc_stall` it loads the R4 next PC of the current fetch, and with `pc_stall` it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | 32 | Address of the instruction fetched this cycle |
| imem_addr | output | 32 | Instruction memory address (the fetch PC) |
| imem_window | input | 48 | Bytes at imem_addr+0..5, byte k in bits 8k+7:8k |
| pc_stall | input | 1 | Hold the PC register |
| fd_stall | input | 1 | Hold the fetch/decode register |
| fd_bubble | input | 1 | Load the bubble record into the fetch/decode register |
| pred_pc | output | 32 | Predicted next PC (PC register) |
| fd_icode | output | 4 | Opcode |
| fd_ifun | output | 4 | Function code |
| fd_ra | output | 4 | Register A specifier |
| fd_rb | output | 4 | Register B specifier |
| fd_valc | output | 32 | Constant word |
| fd_valp | output | 32 | Next sequential PC |
| fd_pc | output | 32 | PC of this record |
| fd_stat | output | 2 | 0 bubble, 1 normal, 2 address error, 3 invalid opcode |

## Verification
The decode and the memory port are combinational, so every result is due one cycle after its stimulus. Each `fd_*` field and `pred_pc` change on the first rising edge after the inputs are driven, and not before.

The driver drives inputs on the falling edge. It pushes the expected record and PC for the next rising edge into a queue. The monitor pops one entry 2 ns after each rising edge and compares it.

Because the queue advances once per cycle, a record that arrives one cycle early or one cycle late is reported. The stall and bubble cases work the same way: the expected entry repeats the held value or carries the bubble record.

// File: rtl/fetch_pkg.sv
`timescale 1ns/1ps
package fetch_pkg;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned WORD_W     = WORD_BYTES * 8;
  localparam int unsigned WIN_BYTES  = 2 + WORD_BYTES;
  localparam int unsigned WIN_W      = WIN_BYTES * 8;

  typedef logic [3:0] nib_t;

  localparam nib_t OP_HALT  = 4'h0;
  localparam nib_t OP_NOP   = 4'h1;
  localparam nib_t OP_RRMOV = 4'h2;
  localparam nib_t OP_IRMOV = 4'h3;
  localparam nib_t OP_RMMOV = 4'h4;
  localparam nib_t OP_MRMOV = 4'h5;
  localparam nib_t OP_ALU   = 4'h6;
  localparam nib_t OP_JUMP  = 4'h7;
  localparam nib_t OP_CALL  = 4'h8;
  localparam nib_t OP_RET   = 4'h9;
  localparam nib_t OP_PUSH  = 4'hA;
  localparam nib_t OP_POP   = 4'hB;
  localparam nib_t REG_NONE = 4'hF;

  typedef enum logic [1:0] {
    ST_BUBBLE = 2'd0,
    ST_OK     = 2'd1,
    ST_ADDR   = 2'd2,
    ST_INSTR  = 2'd3
  } fstat_e;

  typedef struct packed {
    nib_t              icode;
    nib_t              ifun;
    nib_t              ra;
    nib_t              rb;
    logic [WORD_W-1:0] valc;
    logic [ADDR_W-1:0] valp;
    logic [ADDR_W-1:0] pc;
    fstat_e            stat;
  } fd_rec_t;

  localparam fd_rec_t FD_BUBBLE = '{
    icode: OP_NOP, ifun: 4'h0, ra: REG_NONE, rb: REG_NONE,
    valc: '0, valp: '0, pc: '0, stat: ST_BUBBLE
  };
endpackage

// File: rtl/fetch_classify.sv
`timescale 1ns/1ps
// Opcode class: which optional fields follow the first byte, and validity.
module fetch_classify
  import fetch_pkg::*;
(
  input  nib_t op,
  output logic need_reg,
  output logic need_const,
  output logic op_valid
);
  always_comb begin
    need_reg   = 1'b0;
    need_const = 1'b0;
    op_valid   = 1'b1;
    unique case (op)
      OP_HALT, OP_NOP, OP_RET: ;
      OP_RRMOV, OP_ALU, OP_PUSH, OP_POP: need_reg = 1'b1;
      OP_JUMP, OP_CALL: need_const = 1'b1;
      OP_IRMOV, OP_RMMOV, OP_MRMOV: begin
        need_reg   = 1'b1;
        need_const = 1'b1;
      end
      default: op_valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/fetch_extract.sv
`timescale 1ns/1ps
// Field extraction from the byte window plus next-PC arithmetic (R2, R3, R4).
module fetch_extract
  import fetch_pkg::*;
(
  input  logic [ADDR_W-1:0] pc,
  input  logic [WIN_W-1:0]  window,
  input  logic              use_reg,
  input  logic              use_const,
  output nib_t              ra,
  output nib_t              rb,
  output logic [WORD_W-1:0] valc,
  output logic [ADDR_W-1:0] valp
);
  logic [WORD_W-1:0] const_word;

  // Constant bytes start right after the optional register byte.
  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_const_byte
    assign const_word[k*8 +: 8] = use_reg ? window[(k+2)*8 +: 8]
                                          : window[(k+1)*8 +: 8];
  end

  assign ra   = use_reg ? window[15:12] : REG_NONE;
  assign rb   = use_reg ? window[11:8]  : REG_NONE;
  assign valc = use_const ? const_word : '0;
  assign valp = pc + ADDR_W'(1) + ADDR_W'(use_reg)
              + (use_const ? ADDR_W'(WORD_BYTES) : '0);
endmodule

// File: rtl/fetch_pipereg.sv
`timescale 1ns/1ps
// Pipeline register: bubble beats stall; reset loads the bubble value.
module fetch_pipereg #(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stall,
  input  logic         bubble,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n || bubble) q <= INIT;
    else if (!stall)      q <= d;
  end
endmodule

// File: rtl/fetch_stage.sv
`timescale 1ns/1ps
module fetch_stage
  import fetch_pkg::*;
#(
  parameter int unsigned       MEM_BYTES = 4096,
  parameter logic [ADDR_W-1:0] RESET_PC  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic [ADDR_W-1:0] imem_addr,
  input  logic [WIN_W-1:0]  imem_window,
  input  logic              pc_stall,
  input  logic              fd_stall,
  input  logic              fd_bubble,
  output logic [ADDR_W-1:0] pred_pc,
  output logic [3:0]        fd_icode,
  output logic [3:0]        fd_ifun,
  output logic [3:0]        fd_ra,
  output logic [3:0]        fd_rb,
  output logic [WORD_W-1:0] fd_valc,
  output logic [ADDR_W-1:0] fd_valp,
  output logic [ADDR_W-1:0] fd_pc,
  output logic [1:0]        fd_stat
);
  localparam logic [ADDR_W:0] MEM_LIMIT = (ADDR_W+1)'(MEM_BYTES);
  localparam int unsigned     REC_W     = $bits(fd_rec_t);

  logic              fetch_ok;
  nib_t              raw_op, raw_fn;
  logic              cls_reg, cls_const, cls_valid;
  logic              use_reg, use_const;
  nib_t              ex_ra, ex_rb;
  logic [WORD_W-1:0] ex_valc;
  logic [ADDR_W-1:0] seq_pc;
  fd_rec_t           rec_d, rec_q;

  assign imem_addr = fetch_pc;
  assign fetch_ok  = {1'b0, fetch_pc} < MEM_LIMIT;
  assign raw_op    = imem_window[7:4];
  assign raw_fn    = imem_window[3:0];

  fetch_classify u_cls (
    .op(raw_op), .need_reg(cls_reg), .need_const(cls_const), .op_valid(cls_valid)
  );

  // Optional fields only for a readable, defined instruction (R5, R6).
  assign use_reg   = fetch_ok && cls_valid && cls_reg;
  assign use_const = fetch_ok && cls_valid && cls_const;

  fetch_extract u_ext (
    .pc(fetch_pc), .window(imem_window), .use_reg(use_reg), .use_const(use_const),
    .ra(ex_ra), .rb(ex_rb), .valc(ex_valc), .valp(seq_pc)
  );

  always_comb begin
    rec_d.icode = fetch_ok ? raw_op : OP_NOP;
    rec_d.ifun  = fetch_ok ? raw_fn : 4'h0;
    rec_d.ra    = ex_ra;
    rec_d.rb    = ex_rb;
    rec_d.valc  = ex_valc;
    rec_d.valp  = seq_pc;
    rec_d.pc    = fetch_pc;
    if (!fetch_ok)       rec_d.stat = ST_ADDR;
    else if (!cls_valid) rec_d.stat = ST_INSTR;
    else                 rec_d.stat = ST_OK;
  end

  fetch_pipereg #(.W(REC_W), .INIT(REC_W'(FD_BUBBLE))) u_fd_reg (
    .clk(clk), .rst_n(rst_n), .stall(fd_stall), .bubble(fd_bubble),
    .d(rec_d), .q(rec_q)
  );

  fetch_pipereg #(.W(ADDR_W), .INIT(RESET_PC)) u_pc_reg (
    .clk(clk), .rst_n(rst_n), .stall(pc_stall), .bubble(1'b0),
    .d(seq_pc), .q(pred_pc)
  );

  assign fd_icode = rec_q.icode;
  assign fd_ifun  = rec_q.ifun;
  assign fd_ra    = rec_q.ra;
  assign fd_rb    = rec_q.rb;
  assign fd_valc  = rec_q.valc;
  assign fd_valp  = rec_q.valp;
  assign fd_pc    = rec_q.pc;
  assign fd_stat  = rec_q.stat;
endmodule

// File: rtl/fetch_stage_chk.sv
`timescale 1ns/1ps
module fetch_stage_chk
  import fetch_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 4096
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic              pc_stall,
  input logic              fd_stall,
  input logic              fd_bubble,
  input logic [ADDR_W-1:0] pred_pc,
  input logic [ADDR_W-1:0] seq_pc,
  input logic [3:0]        fd_icode,
  input logic [3:0]        fd_ifun,
  input logic [3:0]        fd_ra,
  input logic [3:0]        fd_rb,
  input logic [WORD_W-1:0] fd_valc,
  input logic [ADDR_W-1:0] fd_valp,
  input logic [ADDR_W-1:0] fd_pc,
  input logic [1:0]        fd_stat
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(MEM_BYTES);

  p_no_regs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fd_stat == 2'd1 && (fd_icode <= 4'h1 || (fd_icode >= 4'h7 && fd_icode <= 4'h9)))
    |-> (fd_ra == 4'hF && fd_rb == 4'hF));

  p_length_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fd_stat == 2'd1) |-> ((fd_valp - fd_pc) == 32'd1 || (fd_valp - fd_pc) == 32'd2 ||
                           (fd_valp - fd_pc) == 32'd5 || (fd_valp - fd_pc) == 32'd6));

  p_addr_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fd_stall && !fd_bubble && ({1'b0, fetch_pc} >= LIMIT))
    |=> (fd_stat == 2'd2 && fd_icode == 4'h1 && fd_ifun == 4'h0));

  p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fd_stall && !fd_bubble) |=> (fd_pc == $past(fetch_pc)));

  p_bubble_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fd_bubble |=> (fd_stat == 2'd0 && fd_icode == 4'h1 && fd_ra == 4'hF &&
                   fd_rb == 4'hF && fd_valc == '0));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fd_stall && !fd_bubble) |=> ($stable(fd_icode) && $stable(fd_valc) &&
                                  $stable(fd_valp) && $stable(fd_pc) && $stable(fd_stat)));

  p_pc_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pc_stall |=> $stable(pred_pc));

  p_pc_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_stall |=> (pred_pc == $past(seq_pc)));
endmodule

bind fetch_stage fetch_stage_chk #(.MEM_BYTES(MEM_BYTES)) i_fetch_chk (
  .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pc_stall(pc_stall),
  .fd_stall(fd_stall), .fd_bubble(fd_bubble), .pred_pc(pred_pc), .seq_pc(seq_pc),
  .fd_icode(fd_icode), .fd_ifun(fd_ifun), .fd_ra(fd_ra), .fd_rb(fd_rb),
  .fd_valc(fd_valc), .fd_valp(fd_valp), .fd_pc(fd_pc), .fd_stat(fd_stat)
);

// File: tb/test_fetch_stage.sv
`timescale 1ns/1ps
module test_fetch_stage;
  localparam int MEM = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic [31:0] imem_addr;
  logic [47:0] imem_window;
  logic        pc_stall = 1'b0, fd_stall = 1'b0, fd_bubble = 1'b0;
  logic [31:0] pred_pc, fd_valc, fd_valp, fd_pc;
  logic [3:0]  fd_icode, fd_ifun, fd_ra, fd_rb;
  logic [1:0]  fd_stat;

  logic [7:0] mem [MEM];
  int total = 0, bad = 0;

  typedef struct {
    logic [3:0]  icode, ifun, ra, rb;
    logic [31:0] valc, valp, pc;
    logic [1:0]  stat;
  } rec_t;
  typedef struct {
    rec_t        fd;
    logic [31:0] ppc;
    string       tag;
  } item_t;

  item_t sb_q[$];
  rec_t  exp_fd;
  logic [31:0] exp_pc;

  always #5 clk = ~clk;

  fetch_stage #(.MEM_BYTES(MEM), .RESET_PC(32'h0)) i_fetch_stage (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .imem_addr(imem_addr),
    .imem_window(imem_window), .pc_stall(pc_stall), .fd_stall(fd_stall),
    .fd_bubble(fd_bubble), .pred_pc(pred_pc), .fd_icode(fd_icode), .fd_ifun(fd_ifun),
    .fd_ra(fd_ra), .fd_rb(fd_rb), .fd_valc(fd_valc), .fd_valp(fd_valp),
    .fd_pc(fd_pc), .fd_stat(fd_stat)
  );

  function automatic logic [7:0] rd(input logic [31:0] a);
    return (a < MEM) ? mem[a[5:0]] : 8'h00;
  endfunction

  always_comb begin
    for (int k = 0; k < 6; k++) imem_window[k*8 +: 8] = rd(imem_addr + 32'(k));
  end

  function automatic rec_t bubble_rec();
    rec_t r;
    r.icode = 4'h1; r.ifun = 4'h0; r.ra = 4'hF; r.rb = 4'hF;
    r.valc = '0; r.valp = '0; r.pc = '0; r.stat = 2'd0;
    return r;
  endfunction

  // Reference model written from R1..R6.
  function automatic rec_t model(input logic [31:0] pc);
    rec_t r;
    logic [7:0] b0;
    logic has_r, has_c;
    r.pc = pc; r.ra = 4'hF; r.rb = 4'hF; r.valc = '0;
    if (pc >= MEM) begin
      r.icode = 4'h1; r.ifun = 4'h0; r.stat = 2'd2; r.valp = pc + 1;
      return r;
    end
    b0 = rd(pc);
    r.icode = b0[7:4]; r.ifun = b0[3:0];
    has_r = b0[7:4] inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'hA, 4'hB};
    has_c = b0[7:4] inside {4'h3, 4'h4, 4'h5, 4'h7, 4'h8};
    r.stat = (b0[7:4] > 4'hB) ? 2'd3 : 2'd1;
    if (has_r) begin
      r.ra = rd(pc + 1) >> 4;
      r.rb = rd(pc + 1) & 8'h0F;
    end
    if (has_c)
      for (int k = 0; k < 4; k++)
        r.valc[k*8 +: 8] = rd(pc + 1 + 32'(has_r) + 32'(k));
    r.valp = pc + 1 + 32'(has_r) + (has_c ? 32'd4 : 32'd0);
    return r;
  endfunction

  task automatic chk(input string tag, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, tag, act, exp);
    end
  endtask

  // Driver: drive on the falling edge, push what the next rising edge must give.
  task automatic step(input logic [31:0] pc, input logic fs, input logic fb,
                      input logic ps, input string tag);
    item_t it;
    @(negedge clk);
    fetch_pc = pc; fd_stall = fs; fd_bubble = fb; pc_stall = ps;
    if (fb)       exp_fd = bubble_rec();   // R9
    else if (!fs) exp_fd = model(pc);      // R8 (R10 holds otherwise)
    if (!ps)      exp_pc = model(pc).valp; // R11
    it.fd = exp_fd; it.ppc = exp_pc; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: one scoreboard entry per rising edge, sampled 2 ns later.
  always @(posedge clk) begin
    item_t e;
    #2;
    if (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      chk(e.tag, "R1 icode", 32'(fd_icode), 32'(e.fd.icode));
      chk(e.tag, "R1 ifun",  32'(fd_ifun),  32'(e.fd.ifun));
      chk(e.tag, "R2 ra",    32'(fd_ra),    32'(e.fd.ra));
      chk(e.tag, "R2 rb",    32'(fd_rb),    32'(e.fd.rb));
      chk(e.tag, "R3 valc",  fd_valc,       e.fd.valc);
      chk(e.tag, "R4 valp",  fd_valp,       e.fd.valp);
      chk(e.tag, "R7 pc",    fd_pc,         e.fd.pc);
      chk(e.tag, "R6 stat",  32'(fd_stat),  32'(e.fd.stat));
      chk(e.tag, "R11 pred", pred_pc,       e.ppc);
    end
  end

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] pc;
    for (int i = 0; i < MEM; i++) mem[i] = 8'h00;
    // 0: immediate move, 6 bytes
    mem[0] = 8'h30; mem[1] = 8'hF3; mem[2] = 8'h78; mem[3] = 8'h56; mem[4] = 8'h34; mem[5] = 8'h12;
    // 6: register op, 2 bytes
    mem[6] = 8'h61; mem[7] = 8'h12;
    // 8: jump, 5 bytes
    mem[8] = 8'h73; mem[9] = 8'hEF; mem[10] = 8'hBE; mem[11] = 8'hAD; mem[12] = 8'hDE;
    mem[13] = 8'h10;                   // nop
    mem[14] = 8'hC5;                   // invalid opcode
    mem[15] = 8'h90;                   // return
    mem[16] = 8'hA0; mem[17] = 8'h4F;  // push
    mem[18] = 8'h50; mem[19] = 8'h67; mem[20] = 8'h04; mem[21] = 8'h03;
    mem[22] = 8'h02; mem[23] = 8'h01;  // load move, 6 bytes
    mem[24] = 8'h00;                   // halt
    mem[30] = 8'hF0;                   // invalid opcode 0xF
    mem[62] = 8'h80; mem[63] = 8'hAB;  // call whose constant runs off the end

    repeat (3) @(negedge clk);
    // Reset state: R9 bubble record, R11 reset PC
    chk("reset", "R9 stat",   32'(fd_stat),  32'd0);
    chk("reset", "R9 icode",  32'(fd_icode), 32'd1);
    chk("reset", "R9 ra",     32'(fd_ra),    32'hF);
    chk("reset", "R11 pred",  pred_pc,       32'h0);
    rst_n = 1'b1;
    exp_fd = bubble_rec();
    exp_pc = 32'h0;

    // R8: sequential walk through all lengths (R1-R4, R6)
    pc = 32'h0;
    for (int i = 0; i < 9; i++) begin
      step(pc, 1'b0, 1'b0, 1'b0, "R8 walk");
      pc = model(pc).valp;
    end
    step(32'd30, 1'b0, 1'b0, 1'b0, "R6 op F");
    // R5: addresses beyond memory, edge at MEM
    step(32'd100, 1'b0, 1'b0, 1'b0, "R5 far");
    step(32'd64,  1'b0, 1'b0, 1'b0, "R5 edge");
    step(32'd63,  1'b0, 1'b0, 1'b0, "R6 last byte");
    step(32'd62,  1'b0, 1'b0, 1'b0, "R3 constant past end");
    step(32'd0,   1'b0, 1'b0, 1'b0, "R8 reload");
    // R10: fd stall holds; R11: pc stall holds pred_pc
    step(32'd6,   1'b1, 1'b0, 1'b0, "R10 hold");
    step(32'd8,   1'b1, 1'b0, 1'b1, "R10 R11 hold");
    step(32'd13,  1'b0, 1'b0, 1'b1, "R11 pc hold");
    // R9: bubble, and bubble over stall
    step(32'd8,   1'b0, 1'b1, 1'b0, "R9 bubble");
    step(32'd16,  1'b0, 1'b0, 1'b0, "R8 after bubble");
    step(32'd13,  1'b1, 1'b1, 1'b0, "R9 bubble beats stall");
    step(32'd18,  1'b1, 1'b0, 1'b0, "R10 hold bubble");
    step(32'd18,  1'b0, 1'b0, 1'b0, "R8 resume");
    // Assorted addresses, in range and out (R5, R6)
    for (int i = 0; i < 24; i++)
      step(32'((i * 7) % 70), 1'b0, 1'b0, 1'(i % 5 == 3), "R8 sweep");
    @(negedge clk);
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule